// File: doc/BRIEF.md
# Stepper Driver Mode and Fault Supervisor

This block supervises the power stage of a two-winding stepper driver. It takes the driver's active-low control pins, meaning logic reset, enable and sleep, along with a STEP strobe and three digital protection flags: overcurrent, overtemperature and undervoltage. From these it decides the operating mode on every clock. The mode sets when the bridges conduct and when the outputs float. It also sets when a STEP edge is passed to the indexer, when the indexer is sent back to its home position, and whether the charge pump and internal clocks run.

The three fault classes recover in different ways:

- **Overcurrent:** a persistent overcurrent is qualified over a programmable number of cycles and is then held until a logic reset or a supply loss.
- **Overtemperature:** the overtemperature fault clears as soon as its flag drops.
- **Undervoltage:** an undervoltage puts the whole block back to its reset state.

Leaving sleep or undervoltage starts a settling window. STEP edges are refused until that window has passed.

Every asynchronous input passes through a synchronizer of `SYNC_STAGES` flops before any decision uses it. All cycle counts in the requirements are measured after that synchronizer.

Top module: `stepper_supervisor`

## Requirements
- R1: Each input has a synchronizer of SYNC_STAGES flops (default 2). In run mode, each synchronized rising edge of step_i produces exactly one step_acc_o pulse, and that pulse is one clock long.
- R2: When en_ni is 1, bridge_en_o is 0 and hiz_o is 1, and STEP edges produce no step_acc_o.
- R3: When rst_req_ni is 0, home_o is 1, bridge_en_o is 0 and STEP is ignored. The held overcurrent fault is also cleared, so fault_no returns to 1 unless overtemperature is present.
- R4: When sleep_ni is 0, pump_run_o and bridge_en_o are 0. All other inputs are ignored while asleep: a logic reset does not clear a held overcurrent fault, and the overcurrent flag is not qualified.
- R5: After sleep or undervoltage ends, a STEP edge is accepted only if it arrives at least WAKE_CYC cycles after the release, counting from the release edge to the STEP edge.
- R6: An overcurrent shutdown happens only after the overcurrent flag has been high for OCP_QUAL_CYC consecutive synchronized cycles. On shutdown, fault_no goes to 0 and the bridges turn off. Any low cycle restarts the count.
- R7: An overcurrent shutdown stays in force, with steps ignored, until a logic reset or an undervoltage event.
- R8: While uv_i is 0, an active ot_flag_i drives fault_no to 0 and turns the bridges off. Normal operation resumes by itself once the flag clears.
- R9: While uv_i is 1, all outputs are inactive: bridge_en_o=0, pump_run_o=0, home_o=1, fault_no=1. The internal state is reset, which clears a held overcurrent fault.
- R10: Modes take priority in this order: undervoltage, sleep, logic reset, held overcurrent, overtemperature, disable, run.
- R11: When no fault condition is active, fault_no is 1. In run mode, bridge_en_o is 1 and hiz_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_req_ni | input | 1 | Logic reset request pin, active low |
| en_ni | input | 1 | Output enable pin, active low |
| sleep_ni | input | 1 | Sleep pin, active low |
| step_i | input | 1 | STEP strobe, acted on at its rising edge |
| oc_flag_i | input | 1 | Overcurrent flag, 1 = over limit |
| ot_flag_i | input | 1 | Overtemperature flag, 1 = too hot |
| uv_i | input | 1 | Undervoltage flag, 1 = supply low |
| bridge_en_o | output | 1 | Bridge drive enable |
| hiz_o | output | 1 | Request to float the outputs |
| step_acc_o | output | 1 | One-cycle step pulse to the indexer |
| home_o | output | 1 | Return the step table to home |
| pump_run_o | output | 1 | Charge pump and internal clock run |
| fault_no | output | 1 | Fault indication, active low |

## Verification
Two events can land on the same clock: the wake window running out and a STEP edge arriving. The bench provokes this with a sweep. It releases sleep, then raises STEP at offsets from three cycles before the window ends to two cycles after it. An edge is expected to count only when its offset is at least WAKE_CYC. A second sweep covers overcurrent pulse widths on both sides of the qualification length, to find where the counter completes on the same cycle the flag drops.

// File: rtl/stsup_pkg.sv
package stsup_pkg;
  typedef enum logic [2:0] {
    MD_UV    = 3'd0,
    MD_SLEEP = 3'd1,
    MD_RESET = 3'd2,
    MD_OCP   = 3'd3,
    MD_OTP   = 3'd4,
    MD_OFF   = 3'd5,
    MD_RUN   = 3'd6
  } mode_e;
endpackage

// File: rtl/stsup_sync.sv
module stsup_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/stsup_ocp_qual.sv
module stsup_ocp_qual #(
  parameter int QUAL_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,   // logic reset or undervoltage
  input  logic hold_i,  // sleep: freeze everything
  input  logic flag_i,
  output logic latched_o
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (!hold_i && !lat_q) begin
      if (!flag_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        lat_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/stsup_wake_timer.sv
module stsup_wake_timer #(
  parameter int WAKE_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;

  // power-up counts as a wake as well
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= FULL;
    else if (load_i)         cnt_q <= FULL;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/stsup_mode_arb.sv
module stsup_mode_arb
  import stsup_pkg::*;
(
  input  logic  uv_i,
  input  logic  sleep_i,
  input  logic  rst_req_i,
  input  logic  ocp_lat_i,
  input  logic  otp_i,
  input  logic  dis_i,
  output mode_e mode_o
);
  always_comb begin
    if      (uv_i)      mode_o = MD_UV;
    else if (sleep_i)   mode_o = MD_SLEEP;
    else if (rst_req_i) mode_o = MD_RESET;
    else if (ocp_lat_i) mode_o = MD_OCP;
    else if (otp_i)     mode_o = MD_OTP;
    else if (dis_i)     mode_o = MD_OFF;
    else                mode_o = MD_RUN;
  end
endmodule

// File: rtl/stepper_supervisor.sv
module stepper_supervisor
  import stsup_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int OCP_QUAL_CYC = 400,
  parameter int WAKE_CYC     = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_req_ni,
  input  logic en_ni,
  input  logic sleep_ni,
  input  logic step_i,
  input  logic oc_flag_i,
  input  logic ot_flag_i,
  input  logic uv_i,
  output logic bridge_en_o,
  output logic hiz_o,
  output logic step_acc_o,
  output logic home_o,
  output logic pump_run_o,
  output logic fault_no
);
  localparam int NIN = 7;
  localparam int I_UV = 0, I_OT = 1, I_OC = 2, I_SLP = 3, I_EN = 4, I_RQ = 5, I_STEP = 6;
  // idle levels: pins inactive, outputs disabled until sampled
  localparam logic [NIN-1:0] SYNC_RST = 7'b0111000;

  logic [NIN-1:0] raw, syn;
  logic           step_prev_q;
  logic           ocp_lat, wake_done;
  mode_e          mode;

  assign raw = {step_i, rst_req_ni, en_ni, sleep_ni, oc_flag_i, ot_flag_i, uv_i};

  stsup_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  stsup_mode_arb u_arb (
    .uv_i     (syn[I_UV]),
    .sleep_i  (!syn[I_SLP]),
    .rst_req_i(!syn[I_RQ]),
    .ocp_lat_i(ocp_lat),
    .otp_i    (syn[I_OT]),
    .dis_i    (syn[I_EN]),
    .mode_o   (mode)
  );

  stsup_ocp_qual #(.QUAL_CYC(OCP_QUAL_CYC)) u_ocp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode == MD_UV || mode == MD_RESET),
    .hold_i   (mode == MD_SLEEP),
    .flag_i   (syn[I_OC]),
    .latched_o(ocp_lat)
  );

  stsup_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(mode == MD_UV || mode == MD_SLEEP),
    .done_o(wake_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_prev_q <= 1'b0;
    else         step_prev_q <= syn[I_STEP];
  end

  assign bridge_en_o = (mode == MD_RUN);
  assign hiz_o       = (mode != MD_RUN);
  assign step_acc_o  = (mode == MD_RUN) && wake_done && syn[I_STEP] && !step_prev_q;
  assign home_o      = (mode == MD_UV) || (mode == MD_RESET);
  assign pump_run_o  = (mode != MD_UV) && (mode != MD_SLEEP);
  // over-temperature is not observed while asleep; undervoltage releases all
  assign fault_no    = (mode == MD_UV) ||
                       !(ocp_lat || (syn[I_OT] && mode != MD_SLEEP));
endmodule

// File: rtl/stepper_supervisor_chk.sv
module stepper_supervisor_chk
  import stsup_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  bridge_en_o,
  input logic  hiz_o,
  input logic  step_acc_o,
  input logic  home_o,
  input logic  pump_run_o,
  input logic  fault_no,
  input logic  ocp_lat,
  input mode_e mode
);
  // R1
  step_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_acc_o |=> !step_acc_o);

  // R1
  step_bridge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_acc_o |-> (bridge_en_o && !hiz_o && !home_o));

  // R4
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_SLEEP) |-> (!pump_run_o && !bridge_en_o));

  // R6
  ocp_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_lat && mode != MD_UV) |-> (!fault_no && !bridge_en_o));

  // R7
  ocp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ocp_lat) && !ocp_lat) |-> ($past(mode) == MD_UV || $past(mode) == MD_RESET));

  // R9
  uv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_UV) |-> (fault_no && !pump_run_o && home_o && !bridge_en_o));
endmodule

bind stepper_supervisor stepper_supervisor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bridge_en_o(bridge_en_o),
  .hiz_o      (hiz_o),
  .step_acc_o (step_acc_o),
  .home_o     (home_o),
  .pump_run_o (pump_run_o),
  .fault_no   (fault_no),
  .ocp_lat    (ocp_lat),
  .mode       (mode)
);

// File: tb/stepper_supervisor_bench.sv
module stepper_supervisor_bench;
  localparam int QC = 6;
  localparam int WC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rq_n = 1'b1, en_n = 1'b0, slp_n = 1'b1, step = 1'b0, oc = 1'b0, ot = 1'b0, uv = 1'b0;
  logic bridge, hiz, acc, home, pump, flt_n;
  int   errors = 0, checks = 0, acc_cnt = 0;

  always #2.5 clk = ~clk;

  stepper_supervisor #(.SYNC_STAGES(2), .OCP_QUAL_CYC(QC), .WAKE_CYC(WC)) u_stepper_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_ni(rq_n), .en_ni(en_n), .sleep_ni(slp_n),
    .step_i(step), .oc_flag_i(oc), .ot_flag_i(ot), .uv_i(uv),
    .bridge_en_o(bridge), .hiz_o(hiz), .step_acc_o(acc), .home_o(home),
    .pump_run_o(pump), .fault_no(flt_n)
  );

  always @(negedge clk) if (acc) acc_cnt++;

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      step = 1'b1; wait_n(2);
      step = 1'b0; wait_n(2);
    end
    wait_n(3);
  endtask

  task automatic ocp_pulse(input int w);
    oc = 1'b1; wait_n(w);
    oc = 1'b0; wait_n(5);
  endtask

  task automatic logic_reset();
    rq_n = 1'b0; wait_n(4);
    rq_n = 1'b1; wait_n(4);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int base;
    en_n = 1'b0;
    wait_n(3);
    chk("R11 reset bridge", int'(bridge), 0);
    chk("R11 reset fault_no", int'(flt_n), 1);
    rst_n = 1'b1;
    wait_n(WC + 10);
    chk("R11 run bridge", int'(bridge), 1);
    chk("R11 run hiz", int'(hiz), 0);
    chk("R11 run fault_no", int'(flt_n), 1);

    // R1 step acceptance
    base = acc_cnt; steps(5);
    chk("R1 pulses", acc_cnt - base, 5);

    // R2 disable
    en_n = 1'b1; wait_n(4);
    chk("R2 hiz", int'(hiz), 1);
    chk("R2 bridge", int'(bridge), 0);
    base = acc_cnt; steps(3);
    chk("R2 steps ignored", acc_cnt - base, 0);
    en_n = 1'b0; wait_n(4);

    // R3 logic reset
    rq_n = 1'b0; wait_n(4);
    chk("R3 home", int'(home), 1);
    chk("R3 bridge", int'(bridge), 0);
    base = acc_cnt; steps(2);
    chk("R3 steps ignored", acc_cnt - base, 0);
    rq_n = 1'b1; wait_n(4);
    chk("R3 home release", int'(home), 0);

    // R6 / R7 width sweep around the qualification length
    for (int w = 1; w <= QC + 3; w++) begin
      ocp_pulse(w);
      chk($sformatf("R6 width %0d fault_no", w), int'(flt_n), (w >= QC) ? 0 : 1);
      if (w >= QC) begin
        wait_n(15);
        chk("R7 latch held", int'(flt_n), 0);
        base = acc_cnt; steps(1);
        chk("R7 steps ignored", acc_cnt - base, 0);
        logic_reset();
        chk("R3 latch cleared", int'(flt_n), 1);
      end
    end
    // R6 one low cycle restarts the count
    oc = 1'b1; wait_n(QC - 1); oc = 1'b0; wait_n(1); oc = 1'b1; wait_n(QC - 1); oc = 1'b0;
    wait_n(5);
    chk("R6 gap restarts count", int'(flt_n), 1);

    // R8 overtemperature auto recovery
    ot = 1'b1; wait_n(4);
    chk("R8 fault_no", int'(flt_n), 0);
    chk("R8 bridge", int'(bridge), 0);
    base = acc_cnt; steps(1);
    chk("R8 steps ignored", acc_cnt - base, 0);
    ot = 1'b0; wait_n(4);
    chk("R8 resumed", int'(bridge), 1);
    chk("R8 fault released", int'(flt_n), 1);

    // R4 sleep keeps latch, ignores reset and overcurrent
    ocp_pulse(QC + 2);
    slp_n = 1'b0; wait_n(4);
    chk("R4 pump", int'(pump), 0);
    chk("R4 bridge", int'(bridge), 0);
    rq_n = 1'b0; wait_n(4); rq_n = 1'b1; wait_n(2);
    slp_n = 1'b1; wait_n(WC + 6);
    chk("R4 latch kept over sleep reset", int'(flt_n), 0);
    logic_reset();
    slp_n = 1'b0; wait_n(4);
    oc = 1'b1; wait_n(QC + 4); oc = 1'b0; wait_n(3);
    slp_n = 1'b1; wait_n(WC + 6);
    chk("R4 overcurrent not qualified", int'(flt_n), 1);

    // R5 wake boundary sweep
    for (int k = WC - 3; k <= WC + 2; k++) begin
      slp_n = 1'b0; wait_n(5);
      slp_n = 1'b1; wait_n(k);
      base = acc_cnt;
      step = 1'b1; wait_n(2); step = 1'b0; wait_n(5);
      chk($sformatf("R5 offset %0d", k), acc_cnt - base, (k >= WC) ? 1 : 0);
    end

    // R9 undervoltage
    ocp_pulse(QC + 1);
    uv = 1'b1; wait_n(4);
    chk("R9 pump", int'(pump), 0);
    chk("R9 home", int'(home), 1);
    chk("R9 fault released", int'(flt_n), 1);
    chk("R9 bridge", int'(bridge), 0);
    uv = 1'b0; wait_n(3);
    chk("R9 latch cleared", int'(flt_n), 1);
    base = acc_cnt; steps(1);
    chk("R9 wake restarted", acc_cnt - base, 0);
    wait_n(WC);
    base = acc_cnt; steps(1);
    chk("R9 steps after wake", acc_cnt - base, 1);

    // R10 priority
    slp_n = 1'b0; rq_n = 1'b0; wait_n(4);
    chk("R10 sleep over reset home", int'(home), 0);
    chk("R10 sleep over reset pump", int'(pump), 0);
    uv = 1'b1; wait_n(4);
    chk("R10 uv over sleep home", int'(home), 1);
    uv = 1'b0; slp_n = 1'b1; ot = 1'b1; wait_n(4);
    chk("R10 reset with otp home", int'(home), 1);
    chk("R10 reset with otp fault", int'(flt_n), 0);
    rq_n = 1'b1; en_n = 1'b1; wait_n(4);
    chk("R10 otp over disable fault", int'(flt_n), 0);
    ot = 1'b0; en_n = 1'b0; wait_n(WC + 4);
    chk("R10 back to run", int'(bridge), 1);

    summary();
  end
endmodule